// File: doc/BRIEF.md
# Multi-Channel Clock-Selectable PWM Bank

This block holds a bank of independent 8-bit pulse-width modulators. Every channel keeps its own period and high-time settings and steps its counter on one tick source of its own choosing. Four fixed-rate tick enables come from free-running counters inside the block. A fifth choice is a shared programmable divider, settable from 1 to 255, that counts ticks of the every-cycle source. A channel drives its output high from the start of each period until its counter reaches the pulse-width value. Every change of output level raises a one-cycle flag that the interrupt logic collects.

Software reaches the channels through a small register window. A channel-select register points the clock-choice, period and pulse-width registers at one channel. The divider register is shared by all channels. New period and pulse-width values are held in a pending copy and are only loaded at the end of the running period, so a reprogrammed output never shows a cut-short or stretched pulse.

Top module: `pwm_bank`

## Requirements
- R1: After reset, reads return channel select 00h, clock choice 00h, period FFh, pulse width 80h and divider FFh for every channel.
- R2: Register addresses are: 0 channel select, 1 clock choice, 2 period, 3 pulse width, 4 divider. Addresses 1 to 3 read and write only the channel named by the select register, and leave every other channel as it was. A select write with a value of NUM_CH or more is ignored.
- R3: A channel counter runs from 0 to the active period and then restarts at 0, so one period lasts period+1 ticks. The output is high while the counter is below the active pulse width. A pulse width of 0 gives a constant low output, and a pulse width above the period gives a constant high output.
- R4: Written period and pulse-width values become active only on the tick that restarts the counter. Until then the running period continues unchanged.
- R5: The clock-choice register bits [1:0] select a fixed source when bit 2 is 0. Source 0 ticks once every SRC0_DIV cycles, source 1 once every SRC1_DIV cycles, source 2 once every SRC2_DIV cycles and source 3 once every SRC3_DIV cycles, with each source's phase counted from reset release. When bit 2 is 1 the divider output is selected. Bits [7:3] read as 0.
- R6: A divider value of N yields one divider tick every N ticks of source 1. If the divider count is already at or past N-1 when a source-1 tick arrives, the divider ticks and restarts. A write of 0 to the divider is ignored.
- R7: A channel's edge flag is high exactly in the first cycle the output shows a new level, and low in every other cycle, including the first cycle after reset.
- R8: Addresses 5 to 7 read as 00h, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwm_out | output | NUM_CH | PWM output, one bit per channel |
| pwm_edge | output | NUM_CH | One-cycle output-transition flag per channel |

## Verification
The hardest case to reach is a register write that lands on the same clock edge as a period restart. In that case the shadow load must take the value from before the write, and the write is only picked up at the following boundary. A second hard case is a divider value lowered below the running divider count. Both cases are reached by long stretches of random writes aimed at channels with very short periods on the every-cycle source, so that period boundaries fall in most cycles. A cycle-accurate reference in the bench compares every output and flag on every cycle.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned NSRC = 4;

  localparam logic [AW-1:0] ADR_SEL = 3'd0;
  localparam logic [AW-1:0] ADR_CLK = 3'd1;
  localparam logic [AW-1:0] ADR_PER = 3'd2;
  localparam logic [AW-1:0] ADR_PW  = 3'd3;
  localparam logic [AW-1:0] ADR_DIV = 3'd4;

  localparam logic [DW-1:0] PER_RST = 8'hFF;
  localparam logic [DW-1:0] PW_RST  = 8'h80;
  localparam logic [DW-1:0] DIV_RST = 8'hFF;

  // output level for a counter value against a high time
  function automatic logic pwm_level(input logic [DW-1:0] cnt, input logic [DW-1:0] pw);
    return cnt < pw;
  endfunction

  // last tick of a period
  function automatic logic period_end(input logic [DW-1:0] cnt, input logic [DW-1:0] per);
    return cnt == per;
  endfunction

  // divider count has reached the programmed ratio
  function automatic logic div_due(input logic [DW-1:0] dcnt, input logic [DW-1:0] div);
    return dcnt >= (div - 8'd1);
  endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_bank_pkg::*;
#(
  parameter int unsigned DIV0 = 750,
  parameter int unsigned DIV1 = 1,
  parameter int unsigned DIV2 = 16,
  parameter int unsigned DIV3 = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSRC-1:0] src_tick
);

  function automatic int unsigned src_div(input int k);
    case (k)
      0:       return DIV0;
      1:       return DIV1;
      2:       return DIV2;
      default: return DIV3;
    endcase
  endfunction

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (src_div(k) <= 1) begin : g_every
      assign src_tick[k] = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(src_div(k));
      localparam logic [CW-1:0] LAST = CW'(src_div(k) - 1);
      logic [CW-1:0] cnt;
      logic          hit;
      assign hit = (cnt == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= hit ? '0 : cnt + 1'b1;
      end
      assign src_tick[k] = hit;

      // a divided source never ticks on two cycles in a row
      assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_tick[k] |=> !src_tick[k]);
    end
  end

endmodule

// File: rtl/pwm_divider.sv
module pwm_divider
  import pwm_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic [DW-1:0] div_val,
  output logic          div_tick
);

  logic [DW-1:0] dcnt;

  assign div_tick = base_tick && div_due(dcnt, div_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (base_tick) begin
      dcnt <= div_tick ? '0 : dcnt + 8'd1;
    end
  end

  assert_div_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_val != 8'd0);

  // after a divider tick the next can only follow at once for a ratio of one
  assert_div_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> (!div_tick || div_val == 8'd1));

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [NUM_CH-1:0][2:0]     clk_sel,
  output logic [NUM_CH-1:0][DW-1:0]  per_new,
  output logic [NUM_CH-1:0][DW-1:0]  pw_new,
  output logic [DW-1:0]              div_val
);

  logic [CHW-1:0] sel;
  logic           sel_ok;

  assign sel_ok = (32'(wdata) < 32'(NUM_CH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= '0;
      div_val <= DIV_RST;
    end else if (wr) begin
      if (addr == ADR_SEL && sel_ok)            sel     <= CHW'(wdata);
      if (addr == ADR_DIV && wdata != 8'd0)     div_val <= wdata;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic mine;
    assign mine = wr && (sel == CHW'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        clk_sel[c] <= 3'd0;
        per_new[c] <= PER_RST;
        pw_new[c]  <= PW_RST;
      end else if (mine) begin
        if (addr == ADR_CLK) clk_sel[c] <= wdata[2:0];
        if (addr == ADR_PER) per_new[c] <= wdata;
        if (addr == ADR_PW)  pw_new[c]  <= wdata;
      end
    end
  end

  always_comb begin
    case (addr)
      ADR_SEL: rdata = DW'(sel);
      ADR_CLK: rdata = {5'b0, clk_sel[sel]};
      ADR_PER: rdata = per_new[sel];
      ADR_PW:  rdata = pw_new[sel];
      ADR_DIV: rdata = div_val;
      default: rdata = '0;
    endcase
  end

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel) < 32'(NUM_CH));

  assert_div_zero_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_DIV && wdata == 8'd0) |=> $stable(div_val));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            div_tick,
  input  logic [2:0]      clk_sel,
  input  logic [DW-1:0]   per_new,
  input  logic [DW-1:0]   pw_new,
  output logic            pwm_out,
  output logic            pwm_edge
);

  logic [DW-1:0] cnt;
  logic [DW-1:0] per_act;
  logic [DW-1:0] pw_act;
  logic          prev_out;
  logic          tick;
  logic          wrap;

  assign tick = clk_sel[2] ? div_tick : src_tick[clk_sel[1:0]];
  assign wrap = tick && period_end(cnt, per_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      per_act  <= PER_RST;
      pw_act   <= PW_RST;
      prev_out <= pwm_level('0, PW_RST);
    end else begin
      prev_out <= pwm_out;
      if (wrap) begin
        cnt     <= '0;
        per_act <= per_new;
        pw_act  <= pw_new;
      end else if (tick) begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  assign pwm_out  = pwm_level(cnt, pw_act);
  assign pwm_edge = pwm_out ^ prev_out;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  assert_zero_width_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_act == 8'd0) |-> !pwm_out);

  assert_out_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_out) |-> $past(tick));

  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(per_act) && $stable(pw_act)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned SRC0_DIV = 750,
  parameter int unsigned SRC1_DIV = 1,
  parameter int unsigned SRC2_DIV = 16,
  parameter int unsigned SRC3_DIV = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_edge
);

  logic [NSRC-1:0]            src_tick;
  logic                       div_tick;
  logic [DW-1:0]              div_val;
  logic [NUM_CH-1:0][2:0]     clk_sel;
  logic [NUM_CH-1:0][DW-1:0]  per_new;
  logic [NUM_CH-1:0][DW-1:0]  pw_new;

  pwm_tick_gen #(
    .DIV0(SRC0_DIV), .DIV1(SRC1_DIV), .DIV2(SRC2_DIV), .DIV3(SRC3_DIV)
  ) u_ticks (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick)
  );

  pwm_divider u_div (
    .clk(clk), .rst_n(rst_n), .base_tick(src_tick[1]),
    .div_val(div_val), .div_tick(div_tick)
  );

  pwm_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .clk_sel(clk_sel), .per_new(per_new), .pw_new(pw_new),
    .div_val(div_val)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pwm
    pwm_channel u_ch (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .div_tick(div_tick),
      .clk_sel(clk_sel[c]), .per_new(per_new[c]), .pw_new(pw_new[c]),
      .pwm_out(pwm_out[c]), .pwm_edge(pwm_edge[c])
    );
  end

  // a flag only appears when the matching output has just changed
  assert_edge_tracks_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out == $past(pwm_out)) |-> (pwm_edge == '0));

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

  localparam int NCH = 4;
  localparam int D0 = 40, D1 = 1, D2 = 16, D3 = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] pwm_edge;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R3";

  always #2 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .SRC0_DIV(D0), .SRC1_DIV(D1), .SRC2_DIV(D2), .SRC3_DIV(D3)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_edge(pwm_edge)
  );

  // reference state built from the requirements
  int m_scnt [4];
  int m_dcnt, m_div, m_sel;
  int m_cfg [NCH];
  int m_per [NCH];
  int m_pw  [NCH];
  int m_cnt [NCH];
  int m_pera[NCH];
  int m_pwa [NCH];
  bit m_prev[NCH];

  function automatic int src_div(input int k);
    case (k) 0: return D0; 1: return D1; 2: return D2; default: return D3; endcase
  endfunction

  function automatic bit level(input int cnt, input int pw);
    return cnt < pw;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_scnt[k] = 0;
      m_dcnt = 0; m_div = 255; m_sel = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cfg[c] = 0; m_per[c] = 255; m_pw[c] = 128;
        m_cnt[c] = 0; m_pera[c] = 255; m_pwa[c] = 128; m_prev[c] = 1'b1;
      end
    end else begin
      bit tk[4];
      bit dt;
      for (int k = 0; k < 4; k++)
        tk[k] = (src_div(k) <= 1) ? 1'b1 : (m_scnt[k] == src_div(k) - 1);
      dt = tk[1] && (m_dcnt >= m_div - 1);
      for (int c = 0; c < NCH; c++) begin
        bit t;
        t = m_cfg[c][2] ? dt : tk[m_cfg[c] & 3];
        m_prev[c] = level(m_cnt[c], m_pwa[c]);
        if (t) begin
          if (m_cnt[c] == m_pera[c]) begin
            m_cnt[c] = 0; m_pera[c] = m_per[c]; m_pwa[c] = m_pw[c];
          end else m_cnt[c] = m_cnt[c] + 1;
        end
      end
      for (int k = 0; k < 4; k++)
        if (src_div(k) > 1) m_scnt[k] = tk[k] ? 0 : m_scnt[k] + 1;
      if (tk[1]) m_dcnt = dt ? 0 : (m_dcnt + 1) % 256;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (reg_wdata < NCH) m_sel = reg_wdata;
          3'd1: m_cfg[m_sel] = reg_wdata & 7;
          3'd2: m_per[m_sel] = reg_wdata;
          3'd3: m_pw[m_sel] = reg_wdata;
          3'd4: if (reg_wdata != 0) m_div = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of outputs and flags
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        bit eo, ee;
        eo = level(m_cnt[c], m_pwa[c]);
        ee = (eo != m_prev[c]);
        checks++;
        if (pwm_out[c] !== eo) begin
          errors++;
          $display("FAIL %s ch%0d pwm_out act=%0b exp=%0b t=%0t", cur_tag, c, pwm_out[c], eo, $time);
        end
        checks++;
        if (pwm_edge[c] !== ee) begin
          errors++;
          $display("FAIL R7 ch%0d pwm_edge act=%0b exp=%0b t=%0t", c, pwm_edge[c], ee, $time);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic count_high(input int ch, input int n, output int hi, output int ed);
    hi = 0; ed = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_out[ch]);
      ed += int'(pwm_edge[ch]);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hi, ed;
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(0, 0, "R1 sel");
    rd(1, 0, "R1 clk choice");
    rd(2, 255, "R1 period");
    rd(3, 128, "R1 pulse width");
    rd(4, 255, "R1 divider");
    chk("R1 out at reset", int'(pwm_out), 4'hF);
    // R8 unused addresses
    rd(5, 0, "R8 addr5");
    rd(7, 0, "R8 addr7");

    // R2 indirect access
    wr(0, 1); wr(1, 1); wr(2, 4); wr(3, 0);
    rd(2, 4, "R2 ch1 period");
    wr(0, 0);
    rd(2, 255, "R2 ch0 untouched");
    wr(1, 1); wr(2, 3); wr(3, 9);
    wr(0, 9);
    rd(0, 0, "R2 select out of range ignored");
    wr(0, 2); wr(1, 1); wr(2, 9); wr(3, 3);
    wr(0, 3); wr(1, 2); wr(2, 3); wr(3, 2);
    rd(1, 2, "R5 clk choice readback");

    cur_tag = "R3";
    repeat (300) @(negedge clk);
    count_high(1, 20, hi, ed); chk("R3 zero width stays low", hi, 0);
    count_high(0, 20, hi, ed); chk("R3 width above period stays high", hi, 20);
    count_high(2, 100, hi, ed); chk("R3 duty 3 of 10", hi, 30);
    cur_tag = "R5";
    repeat (4200) @(negedge clk);
    count_high(3, 640, hi, ed); chk("R5 divided source duty", hi, 320);

    // R4 mid-period reprogramming checked cycle by cycle
    cur_tag = "R4";
    wr(0, 2); wr(2, 19); wr(3, 10);
    rd(2, 19, "R4 pending period readback");
    repeat (60) @(negedge clk);
    count_high(2, 200, hi, ed); chk("R4 new duty after boundary", hi, 100);

    // R6 divider
    cur_tag = "R6";
    wr(4, 0);
    rd(4, 255, "R6 zero write ignored");
    wr(4, 5);
    wr(0, 0); wr(1, 4); wr(2, 1); wr(3, 1);
    repeat (600) @(negedge clk);
    count_high(0, 100, hi, ed);
    chk("R6 divide by five duty", hi, 50);
    chk("R7 edge count", ed, 20);

    // R8 writes to unused addresses
    wr(6, 8'h55); wr(7, 1); wr(5, 3);
    rd(0, 0, "R8 sel kept");
    rd(1, 4, "R8 clk choice kept");
    rd(2, 1, "R8 period kept");
    rd(3, 1, "R8 width kept");
    rd(4, 5, "R8 divider kept");

    // random writes, short periods on fast sources mostly
    cur_tag = "R3";
    for (int i = 0; i < 2500; i++) begin
      int a, d;
      a = $urandom % 8;
      d = $urandom % 256;
      if (a == 1) d = ($urandom % 4 == 0) ? 4 + ($urandom % 4) : 1 + ($urandom % 2);
      if (a == 2 || a == 3 || a == 4) d = $urandom % 8;
      if (a == 0) d = $urandom % 6;
      wr(a, d);
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule